// File: doc/BRIEF.md
# Binary Early/Late Clock Phase Detector

This block judges, once per bit, whether a recovered clock sits ahead of or behind a full-rate NRZ data stream, and turns each judgement into a single-cycle correction request. The recovered clock samples the data at two points in every bit. The rising edge takes a centre sample. The falling edge takes a boundary sample half a bit later, where a data transition is expected. Three aligned samples are then compared: the earlier centre bit, the boundary sample between the two centre bits, and the later centre bit. From them the block decides late, early or no information.

Each lane holds a small pump state machine with three states. `ST_HOLD` drives neither output. `ST_PUMP_UP` drives `up` and `ST_PUMP_DN` drives `dn`. The machine is re-evaluated on every rising edge, with these transitions:

- any state goes to `ST_PUMP_UP` on a late verdict;
- any state goes to `ST_PUMP_DN` on an early verdict;
- any state goes to `ST_HOLD` when no transition was seen.

A correction therefore lasts one clock period per observed transition, and a long run of equal bits leaves both outputs low. `LANES` independent lanes share the one recovered clock and the active-low asynchronous reset.

Top module: `bbpd_early_late`

## Requirements
- R1: On every rising clock edge each lane captures its data input. `dout` shows the value captured at the most recent rising edge.
- R2: On every falling clock edge each lane captures a boundary sample. That sample is the one judged between the centre bits captured at the rising edges before and after it.
- R3: Let a lane's centre bits be b(k-1) and b(k), captured at rising edges k-1 and k. If they differ and the boundary sample between them equals b(k), the clock is late. `up` of that lane is 1 and `dn` is 0 during the cycle that follows rising edge k+1.
- R4: Under the same timing, if b(k-1) and b(k) differ and the boundary sample equals b(k-1), the clock is early. `dn` is 1 and `up` is 0.
- R5: If b(k-1) equals b(k), both `up` and `dn` of that lane are 0 in that cycle, whatever the boundary sample was.
- R6: Each observed transition yields exactly one clock period of correction. A run of equal bits produces no further pulse after that one.
- R7: `up` and `dn` of one lane are never 1 together.
- R8: While `rst_n` is 0, every sampling and output register is cleared at once, without waiting for a clock. After release, the first decision treats 0 as the earlier centre bit and 0 as the earlier boundary sample.
- R9: Each lane's decisions depend only on that lane's data input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Recovered clock; rising edge takes centre samples, falling edge takes boundary samples |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | LANES | Serial NRZ data, one bit per lane |
| up | output | LANES | Late verdict pulse, one clock period, per lane |
| dn | output | LANES | Early verdict pulse, one clock period, per lane |
| dout | output | LANES | Retimed data, centre sample per lane |

## Verification
The bench builds the block with `LANES` set to 2. The two lanes are fed different centre and boundary patterns in the same cycle, so a swap or a leak between lanes changes an observed pulse. Boundary samples are driven separately from centre samples, so late, early and no-transition cases all occur under the three-cycle alignment. The bench also covers a transition into a long constant run and a reset asserted in the middle of traffic.

// File: rtl/bbpd_pkg.sv
package bbpd_pkg;

    // Three samples of one lane, aligned to the rising edge
    typedef struct packed {
        logic old_bit;   // centre sample one cycle back
        logic edge_bit;  // boundary sample between old and new
        logic new_bit;   // most recent centre sample
    } bbpd_trio_t;

    // Judgement of one trio
    typedef enum logic [1:0] {
        VD_NONE  = 2'b00,
        VD_LATE  = 2'b01,
        VD_EARLY = 2'b10
    } bbpd_verdict_t;

    // Pump state; bit 0 drives up, bit 1 drives dn
    typedef enum logic [1:0] {
        ST_HOLD    = 2'b00,
        ST_PUMP_UP = 2'b01,
        ST_PUMP_DN = 2'b10
    } bbpd_pump_t;

endpackage

// File: rtl/bbpd_sampler.sv
module bbpd_sampler
    import bbpd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       din,
    output bbpd_trio_t trio
);

    logic ctr_q;      // centre sample, rising edge
    logic bnd_q;      // boundary sample, falling edge
    logic ctr_old_q;  // centre sample delayed one cycle
    logic bnd_rt_q;   // boundary sample moved onto the rising edge

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctr_q     <= 1'b0;
            ctr_old_q <= 1'b0;
            bnd_rt_q  <= 1'b0;
        end else begin
            ctr_q     <= din;
            ctr_old_q <= ctr_q;
            bnd_rt_q  <= bnd_q;
        end
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bnd_q <= 1'b0;
        end else begin
            bnd_q <= din;
        end
    end

    always_comb begin
        trio.old_bit  = ctr_old_q;
        trio.edge_bit = bnd_rt_q;
        trio.new_bit  = ctr_q;
    end

endmodule

// File: rtl/bbpd_judge.sv
module bbpd_judge
    import bbpd_pkg::*;
(
    input  bbpd_trio_t    trio,
    output bbpd_verdict_t verdict
);

    always_comb begin
        if (trio.old_bit == trio.new_bit) begin
            verdict = VD_NONE;           // no transition, no information
        end else if (trio.edge_bit == trio.new_bit) begin
            verdict = VD_LATE;           // boundary already shows new bit
        end else begin
            verdict = VD_EARLY;          // boundary still shows old bit
        end
    end

endmodule

// File: rtl/bbpd_pump_fsm.sv
module bbpd_pump_fsm
    import bbpd_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  bbpd_verdict_t verdict,
    output logic          up,
    output logic          dn
);

    bbpd_pump_t state_q;
    bbpd_pump_t state_d;

    always_comb begin
        case (verdict)
            VD_LATE:  state_d = ST_PUMP_UP;
            VD_EARLY: state_d = ST_PUMP_DN;
            default:  state_d = ST_HOLD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HOLD;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        up = 1'b0;
        dn = 1'b0;
        case (state_q)
            ST_PUMP_UP: up = 1'b1;
            ST_PUMP_DN: dn = 1'b1;
            default: begin
                up = 1'b0;
                dn = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/bbpd_early_late.sv
module bbpd_early_late
    import bbpd_pkg::*;
#(
    parameter int LANES = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] din,
    output logic [LANES-1:0] up,
    output logic [LANES-1:0] dn,
    output logic [LANES-1:0] dout
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        bbpd_trio_t    trio;
        bbpd_verdict_t verdict;

        bbpd_sampler u_smp (
            .clk   (clk),
            .rst_n (rst_n),
            .din   (din[g]),
            .trio  (trio)
        );

        bbpd_judge u_jdg (
            .trio    (trio),
            .verdict (verdict)
        );

        bbpd_pump_fsm u_pump (
            .clk     (clk),
            .rst_n   (rst_n),
            .verdict (verdict),
            .up      (up[g]),
            .dn      (dn[g])
        );

        assign dout[g] = trio.new_bit;
    end

endmodule

// File: rtl/bbpd_checks.sv
module bbpd_checks #(
    parameter int LANES = 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic [LANES-1:0] din,
    input logic [LANES-1:0] up,
    input logic [LANES-1:0] dn,
    input logic [LANES-1:0] dout
);

    for (genvar g = 0; g < LANES; g++) begin : g_chk
        // R7
        pump_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(up[g] && dn[g]));

        // R5
        quiet_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (up[g] || dn[g]) |-> ($past(dout[g], 2) != $past(dout[g], 1)));

        // R6 (with R3 and R4: a transition gives exactly one pulse)
        one_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(dout[g], 2) != $past(dout[g], 1)) |-> (up[g] ^ dn[g]));

        // R8
        reset_clear_chk: assert property (@(posedge clk)
            !rst_n |-> (!up[g] && !dn[g] && !dout[g]));
    end

    // R1: the retimed output follows the input one rising edge later
    logic unused_din;
    assign unused_din = ^din;

endmodule

bind bbpd_early_late bbpd_checks #(.LANES(LANES)) u_bbpd_checks (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (din),
    .up    (up),
    .dn    (dn),
    .dout  (dout)
);

// File: tb/bbpd_early_late_tb_top.sv
`timescale 1ns/1ps
module bbpd_early_late_tb_top;

    localparam int L = 2;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [L-1:0] din = '0;
    logic [L-1:0] up, dn, dout;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // Model history: centre bits and boundary samples of earlier cycles
    logic [L-1:0] c_m1 = '0, c_m2 = '0, e_m1 = '0, e_m2 = '0;
    int pulse_cnt = 0;

    // Each entry: [3:2] centre bits (lane1,lane0), [1:0] boundary bits
    localparam logic [3:0] VEC [16] = '{
        4'b0101, 4'b1000, 4'b0110, 4'b1111,
        4'b0100, 4'b1001, 4'b0011, 4'b1110,
        4'b0100, 4'b1011, 4'b0001, 4'b1100,
        4'b1110, 4'b0010, 4'b0111, 4'b1000
    };

    always #5 clk = ~clk;

    bbpd_early_late #(.LANES(L)) dut_i (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (din),
        .up    (up),
        .dn    (dn),
        .dout  (dout)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // One bit period: centre value before the rising edge, boundary value before the falling edge
    task automatic step(input logic [L-1:0] c, input logic [L-1:0] e);
        logic [L-1:0] trans, exp_up, exp_dn;
        @(negedge clk); #1 din = c;
        @(posedge clk); #1 din = e;
        #1;
        trans  = c_m2 ^ c_m1;
        exp_up = trans & ~(e_m2 ^ c_m1);
        exp_dn = trans & ~(e_m2 ^ c_m2);
        chk("R1 centre sample on dout", {6'b0, dout}, {6'b0, c});
        chk("R3 R2 R9 late pulse", {6'b0, up}, {6'b0, exp_up});
        chk("R4 R2 R9 early pulse", {6'b0, dn}, {6'b0, exp_dn});
        chk("R5 quiet without transition", {6'b0, (up | dn) & ~trans}, 8'd0);
        chk("R7 up and dn exclusive", {6'b0, up & dn}, 8'd0);
        if (up[0] || dn[0]) pulse_cnt++;
        c_m2 = c_m1; e_m2 = e_m1;
        c_m1 = c;    e_m1 = e;
    endtask

    task automatic clear_model();
        c_m1 = '0; c_m2 = '0; e_m1 = '0; e_m2 = '0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        // Reset state
        din = 2'b11;
        repeat (3) @(posedge clk);
        #2;
        chk("R8 outputs clear in reset", {2'b0, up, dn, dout}, 8'd0);
        @(negedge clk); #1 din = '0; rst_n = 1'b1;

        // Vector table
        for (int k = 0; k < 16; k++) begin
            step(VEC[k][3:2], VEC[k][1:0]);
        end

        // Long run: one transition then constant data
        repeat (4) step(2'b11, 2'b11);
        pulse_cnt = 0;
        repeat (14) step(2'b00, 2'b00);
        chk("R6 one pulse per transition", pulse_cnt[7:0], 8'd1);

        // Boundary samples alternate while centre bits hold: no effect
        pulse_cnt = 0;
        for (int k = 0; k < 8; k++) begin
            step(2'b00, (k % 2 == 0) ? 2'b11 : 2'b00);
        end
        chk("R5 R6 boundary ignored on constant data", pulse_cnt[7:0], 8'd0);

        // Asynchronous reset in the middle of traffic
        step(2'b10, 2'b01);
        step(2'b01, 2'b11);
        #1 rst_n = 1'b0;
        #1 chk("R8 asynchronous clear", {2'b0, up, dn, dout}, 8'd0);
        @(posedge clk);
        @(posedge clk);
        @(negedge clk); #1 din = '0; rst_n = 1'b1;
        clear_model();
        step(2'b11, 2'b00);
        step(2'b11, 2'b11);
        chk("R8 first decision uses cleared history", {6'b0, dn}, 8'd3);
        step(2'b01, 2'b01);
        step(2'b10, 2'b10);
        step(2'b10, 2'b00);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule